// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a simple synchronous request port to an external asynchronous static RAM of 512K words by 16 bits. A requester presents a word address, a write flag, write data and a two-bit byte mask. The controller then runs the pin sequence for a read or a write on the memory side. Completion is signalled by a one-cycle ready pulse, and for reads the captured word is returned.

The memory is selected through a pair of chip enables of opposite polarity. Each byte lane has its own active-low strobe. Only the lanes enabled by the mask are strobed. The access window is a number of clock cycles derived from the memory access time and the clock period, rounded up. Between requests every control pin rests in the deselected state, so the memory can drop into its automatic power-down.

The 16-bit bidirectional data bus is represented by three signals: an output word, a drive enable and an input word. The controller only drives the bus during a write. It never drives the bus while it holds the memory's output enable low.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset and whenever idle: mem_ce1_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1, mem_lb_n=1, mem_ub_n=1, mem_dq_oe=0 and req_ready=0.
- R2: A read with a nonzero mask selects the chip (mem_ce1_n=0, mem_ce2=1) with mem_we_n=1 and mem_oe_n=0 for exactly WAIT_CYC cycles. Mask bit 0 drives mem_lb_n low, for lane DQ[7:0]. Mask bit 1 drives mem_ub_n low, for lane DQ[15:8].
- R3: rsp_rdata takes the bus word sampled on the last read-access cycle, with unmasked lanes forced to zero. req_ready pulses in the cycle after that access window, which is WAIT_CYC+1 cycles after acceptance. rsp_rdata then holds until the next read completes.
- R4: A write first spends one setup cycle with the chip selected, address and byte strobes valid, and mem_we_n=1. It then drives mem_we_n low for exactly WAIT_CYC cycles with address and strobes unchanged. Last comes one hold cycle with mem_we_n=1, the chip still selected, and the same data still driven. req_ready follows WAIT_CYC+3 cycles after acceptance.
- R5: mem_dq_oe is never high while mem_oe_n is low, and never high while the chip is deselected.
- R6: A write changes only the byte lanes whose mask bit is 1. The other lane of the word keeps its contents.
- R7: A request with mask 2'b00 completes with req_ready one cycle after acceptance, and the chip is never selected. For a read, rsp_rdata becomes zero.
- R8: Each accepted request produces exactly one req_ready pulse, one cycle wide. req_valid is sampled only while idle. A req_valid raised during an access, including its ready cycle, starts no memory cycle.
- R9: The two chip enables always switch together (mem_ce1_n equals the inverse of mem_ce2). mem_we_n is never low and no byte strobe is low while the chip is deselected.
- R10: WAIT_CYC equals ACCESS_NS divided by CLK_NS, rounded up (6 cycles at 55 ns and 10 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes to access (bit 0 lower, bit 1 upper) |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read word, unmasked lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lb_n | output | 1 | Active-low lower byte strobe |
| mem_ub_n | output | 1 | Active-low upper byte strobe |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
Two events can land in the same cycle: the completion pulse of one access and a fresh request strobe from the requester. The bench watches for the ready pulse of a write. In that same cycle it raises req_valid with a different address, and it also raises req_valid part-way through the write pulse. The result is judged at the pins and through a later read-back. There must be one ready pulse, no extra write-enable cycles and no extra chip selection, and the stray address must be unchanged. A read followed directly by a write covers the other overlap, the release of output enable against the start of bus drive; a negative-edge monitor counts any cycle in which both are active.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 16;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_DONE
    } ctl_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } req_t;

    typedef struct packed {
        logic             ce1_n;
        logic             ce2;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] bsel_n;
        logic             drive;
    } pin_ctl_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic logic [DATA_W-1:0] keep_lanes(input logic [DATA_W-1:0] data,
                                                     input logic [LANES-1:0]  mask);
        logic [DATA_W-1:0] res;
        for (int i = 0; i < LANES; i++)
            res[i*LANE_W +: LANE_W] = mask[i] ? data[i*LANE_W +: LANE_W] : '0;
        return res;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int WAIT_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic last
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CW'(WAIT_CYC - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/sram_pin_map.sv
module sram_pin_map
    import sram_ctrl_pkg::*;
(
    input  ctl_state_e       state,
    input  logic [LANES-1:0] mask,
    output pin_ctl_t         pins
);
    logic active;

    always_comb begin
        active       = 1'b0;
        pins.ce1_n   = 1'b1;
        pins.ce2     = 1'b0;
        pins.we_n    = 1'b1;
        pins.oe_n    = 1'b1;
        pins.drive   = 1'b0;
        unique case (state)
            ST_RD: begin
                active    = 1'b1;
                pins.oe_n = 1'b0;
            end
            ST_WSETUP, ST_WHOLD: begin
                active     = 1'b1;
                pins.drive = 1'b1;
            end
            ST_WPULSE: begin
                active     = 1'b1;
                pins.we_n  = 1'b0;
                pins.drive = 1'b1;
            end
            default: active = 1'b0;
        endcase
        if (active) begin
            pins.ce1_n = 1'b0;
            pins.ce2   = 1'b1;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pins.bsel_n[g] = !(active && mask[g]);
    end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ACCESS_NS = 55,
    parameter int CLK_NS    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int WAIT_CYC = ceil_div(ACCESS_NS, CLK_NS);

    ctl_state_e  state, state_nx;
    req_t        req_q;
    pin_ctl_t    pins;
    logic        accept, empty_mask, tmr_load, tmr_last;
    logic [DATA_W-1:0] rdata_q;

    assign accept     = (state == ST_IDLE) && req_valid;
    assign empty_mask = (req_mask == '0);
    assign tmr_load   = (accept && !empty_mask && !req_write) || (state == ST_WSETUP);

    sram_wait_timer #(.WAIT_CYC(WAIT_CYC)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .last (tmr_last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid)
                           state_nx = empty_mask ? ST_DONE : (req_write ? ST_WSETUP : ST_RD);
            ST_RD:     if (tmr_last) state_nx = ST_DONE;
            ST_WSETUP: state_nx = ST_WPULSE;
            ST_WPULSE: if (tmr_last) state_nx = ST_WHOLD;
            ST_WHOLD:  state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            rdata_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                req_q.write <= req_write;
                req_q.addr  <= req_addr;
                req_q.wdata <= req_wdata;
                req_q.mask  <= req_mask;
                if (!req_write && empty_mask)
                    rdata_q <= '0;
            end
            if (state == ST_RD && tmr_last)
                rdata_q <= keep_lanes(mem_dq_in, req_q.mask);
        end
    end

    sram_pin_map i_pins (
        .state (state),
        .mask  (req_q.mask),
        .pins  (pins)
    );

    assign req_ready  = (state == ST_DONE);
    assign rsp_rdata  = rdata_q;
    assign mem_addr   = req_q.addr;
    assign mem_ce1_n  = pins.ce1_n;
    assign mem_ce2    = pins.ce2;
    assign mem_we_n   = pins.we_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_lb_n   = pins.bsel_n[0];
    assign mem_ub_n   = pins.bsel_n[1];
    assign mem_dq_out = req_q.wdata;
    assign mem_dq_oe  = pins.drive;

    a_r5_no_drive_with_oe: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    a_r5_no_drive_desel: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_ce1_n && mem_ce2));

    a_r1_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n));

    a_r9_we_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2));

    a_r4_addr_stable_we: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !$past(rst)) |-> $stable(mem_addr));

    a_r2_read_we_high: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);

    a_r8_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    a_r7_empty_mask_fast: assert property (@(posedge clk) disable iff (rst)
        (accept && empty_mask) |=> (req_ready && mem_ce1_n));

endmodule

// File: tb/test_sram_byte_ctrl.sv
module test_sram_byte_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_NS     = 55;
    localparam int W_EXP      = (ACC_NS + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int n_tests = 0, n_fail = 0;
    logic [15:0] mem [int];
    int n_we_low, n_rd_cyc, n_sel_cyc, n_ready;
    int v_drive = 0, v_desel = 0, v_ce = 0, v_setup = 0, v_hold = 0;
    logic        p_sel = 1'b0, p_we_n = 1'b1;
    logic [18:0] p_addr = '0;
    logic [1:0]  p_bsel = 2'b11;
    logic [15:0] p_dq = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_byte_ctrl #(.ACCESS_NS(ACC_NS), .CLK_NS(CLK_PERIOD)) i_sram_byte_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [15:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    wire sel = !mem_ce1_n && mem_ce2;

    always_comb begin
        mem_dq_in = 16'hEEEE;
        if (sel && mem_we_n && !mem_oe_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = mem_rd(int'(mem_addr))[7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = mem_rd(int'(mem_addr))[15:8];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [15:0] w;
            if (mem_dq_oe && !mem_oe_n) v_drive++;
            if (!sel && (mem_dq_oe || !mem_we_n || !mem_lb_n || !mem_ub_n)) v_desel++;
            if (mem_ce1_n != !mem_ce2) v_ce++;
            if (sel) n_sel_cyc++;
            if (sel && !mem_oe_n) n_rd_cyc++;
            if (req_ready) n_ready++;
            if (!mem_we_n) begin
                n_we_low++;
                if (!mem_dq_oe) v_hold++;
                w = mem_rd(int'(mem_addr));
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                mem[int'(mem_addr)] = w;
            end
            if (p_we_n && !mem_we_n &&
                !(p_sel && p_addr == mem_addr && p_bsel == {mem_ub_n, mem_lb_n})) v_setup++;
            if (!p_we_n && mem_we_n && !(sel && mem_dq_oe && mem_dq_out == p_dq)) v_hold++;
            p_sel = sel; p_we_n = mem_we_n; p_addr = mem_addr;
            p_bsel = {mem_ub_n, mem_lb_n}; p_dq = mem_dq_out;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input logic [18:0] a, input logic [15:0] d,
                          input logic [1:0] m, output int lat);
        @(negedge clk);
        n_we_low = 0; n_rd_cyc = 0; n_sel_cyc = 0; n_ready = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            lat++;
            if (req_ready) break;
        end
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n
              && !mem_dq_oe && !req_ready, "R1 reset pins",
              {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready},
              8'b10111100);
    endtask

    task automatic t_read;
        int lat;
        mem[19'h12345] = 16'hA55A;
        mem[19'h7FFFF] = 16'h0FF0;
        do_req(1'b0, 19'h12345, 16'h0, 2'b11, lat);
        check(rsp_rdata == 16'hA55A, "R3 read full word", rsp_rdata, 16'hA55A);
        check(lat == W_EXP + 1, "R3 read latency", lat, W_EXP + 1);
        check(n_rd_cyc == W_EXP, "R2 OE low window", n_rd_cyc, W_EXP);
        check(n_rd_cyc == W_EXP, "R10 wait equals ceil(access/clock)", n_rd_cyc, W_EXP);
        check(n_ready == 1, "R8 one ready per read", n_ready, 1);
        do_req(1'b0, 19'h12345, 16'h0, 2'b01, lat);
        check(rsp_rdata == 16'h005A, "R2 lower lane only", rsp_rdata, 16'h005A);
        do_req(1'b0, 19'h12345, 16'h0, 2'b10, lat);
        check(rsp_rdata == 16'hA500, "R2 upper lane only", rsp_rdata, 16'hA500);
        do_req(1'b0, 19'h7FFFF, 16'h0, 2'b11, lat);
        check(rsp_rdata == 16'h0FF0, "R3 top address", rsp_rdata, 16'h0FF0);
        repeat (3) @(negedge clk);
        check(rsp_rdata == 16'h0FF0, "R3 read data held", rsp_rdata, 16'h0FF0);
    endtask

    task automatic t_write;
        int lat;
        do_req(1'b1, 19'h00ABC, 16'h1234, 2'b11, lat);
        check(lat == W_EXP + 3, "R4 write latency", lat, W_EXP + 3);
        check(n_we_low == W_EXP, "R4 WE low cycles", n_we_low, W_EXP);
        check(n_sel_cyc == W_EXP + 2, "R4 selected cycles incl setup+hold", n_sel_cyc, W_EXP + 2);
        check(v_setup == 0, "R4 setup before WE", v_setup, 0);
        check(v_hold == 0, "R4 data held after WE", v_hold, 0);
        do_req(1'b1, 19'h00ABC, 16'hABCD, 2'b01, lat);
        do_req(1'b0, 19'h00ABC, 16'h0, 2'b11, lat);
        check(rsp_rdata == 16'h12CD, "R6 lower lane write", rsp_rdata, 16'h12CD);
        do_req(1'b1, 19'h00ABC, 16'h5678, 2'b10, lat);
        do_req(1'b0, 19'h00ABC, 16'h0, 2'b11, lat);
        check(rsp_rdata == 16'h56CD, "R6 upper lane write", rsp_rdata, 16'h56CD);
    endtask

    task automatic t_empty_mask;
        int lat;
        do_req(1'b1, 19'h00ABC, 16'hFFFF, 2'b00, lat);
        check(lat == 1, "R7 empty write latency", lat, 1);
        check(n_sel_cyc == 0, "R7 empty write no select", n_sel_cyc, 0);
        do_req(1'b0, 19'h00ABC, 16'h0, 2'b00, lat);
        check(rsp_rdata == 16'h0000 && lat == 1, "R7 empty read", rsp_rdata, 0);
        do_req(1'b0, 19'h00ABC, 16'h0, 2'b11, lat);
        check(rsp_rdata == 16'h56CD, "R7 memory untouched", rsp_rdata, 16'h56CD);
    endtask

    task automatic t_collide;
        int cnt;
        mem[19'h00777] = 16'h7777;
        @(negedge clk);
        n_we_low = 0; n_sel_cyc = 0; n_ready = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00100;
        req_wdata = 16'hBEEF; req_mask = 2'b11;
        @(posedge clk);
        #1 req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_addr = 19'h00777; req_wdata = 16'hDEAD; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!req_ready && cnt < 100) begin @(negedge clk); cnt++; end
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        repeat (W_EXP + 6) @(negedge clk);
        #1;
        check(n_ready == 1, "R8 single ready under collision", n_ready, 1);
        check(n_we_low == W_EXP, "R8 no extra write", n_we_low, W_EXP);
        check(n_sel_cyc == W_EXP + 2, "R8 no extra select", n_sel_cyc, W_EXP + 2);
        begin
            int lat;
            do_req(1'b0, 19'h00777, 16'h0, 2'b11, lat);
            check(rsp_rdata == 16'h7777, "R8 stray address unchanged", rsp_rdata, 16'h7777);
            do_req(1'b1, 19'h00100, 16'h4321, 2'b11, lat);
            do_req(1'b0, 19'h00100, 16'h0, 2'b11, lat);
            check(rsp_rdata == 16'h4321, "R5 read/write turnaround", rsp_rdata, 16'h4321);
        end
    endtask

    initial begin
        int wd = 0;
        while (wd < 50000 && n_tests < 1000) begin
            @(posedge clk);
            wd++;
        end
        if (wd >= 50000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", wd, 50000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_read();
        t_write();
        t_empty_mask();
        t_collide();
        check(v_drive == 0, "R5 drive while OE low", v_drive, 0);
        check(v_desel == 0, "R9 activity while deselected", v_desel, 0);
        check(v_ce == 0, "R9 enables switch together", v_ce, 0);
        check(v_setup == 0 && v_hold == 0, "R4 write timing overall", v_setup + v_hold, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule